// File: doc/BRIEF.md
# Iterative Integer Multiplier with Word, Doubleword and Multiply-Add Forms

This block multiplies two 64-bit integer operands over many clock cycles and returns one 64-bit slice of the product. A four-bit operation code chooses operand width (a 32-bit word taken from the low half of each operand, or the full 64-bit doubleword), signed or unsigned interpretation, and which part of the product is returned. The choices are the low half, the high half, or the upper word of a word product copied into both halves of the result. A multiply-add variant extends a third operand to 128 bits and adds it to the full product before the slice is taken. A second variant multiplies by a sign-extended 16-bit immediate carried in the low bits of operand B.

The core is a radix-2 shift-add engine working on operand magnitudes. The sign is applied once the iterations end. Word forms run half as many iterations as doubleword forms. A caller pulses `start` while the unit is idle, then waits for the one-cycle `done` pulse. The result, the overflow flag and the three-bit comparison field stay valid until the next `done`. An overflow-enable input qualifies the overflow flag. A record input qualifies the comparison field.

Top module: `mulx_unit`

## Requirements
- R1: `start` is accepted only while `busy` is low. `busy` is high from the cycle after acceptance until the cycle in which `done` is high. `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R2: A `start` pulse while `busy` is high is ignored. The running operation completes with its own operands, and no further `done` follows.
- R3: `done` is high N+1 clock cycles after the edge that accepts `start`. N is 32 for codes 3, 4 and 5, and 64 for every other code.
- R4: Code 0 returns the low 64 bits of the signed 64x64 product of A and B.
- R5: Code 1 returns the high 64 bits of the signed 128-bit product. Code 2 returns the high 64 bits of the unsigned product.
- R6: Code 3 multiplies the signed low 32 bits of A and B and returns the full 64-bit product. The upper 32 bits of each operand have no effect.
- R7: Codes 4 (signed) and 5 (unsigned) form the 64-bit product of the low 32 bits of A and B. The product's bits 63:32 are placed in both result bits 63:32 and result bits 31:0.
- R8: Code 6 multiplies A by B[15:0] sign-extended to 64 bits and returns the low 64 bits. B[63:16] has no effect.
- R9: Code 7 adds C sign-extended to the signed 128-bit product and returns the high 64 bits of the sum. Code 8 adds C zero-extended to the unsigned product and returns the high 64 bits. Code 9 adds C sign-extended to the signed product and returns the low 64 bits.
- R10: With `oe`=1, `ovf` is set for code 0 when bits 127:63 of the product are neither all zero nor all one. It is set for code 3 when bits 63:31 of the 64-bit product are neither all zero nor all one. In every other case `ovf` is 0.
- R11: With `rc`=1, `cond` describes the 64-bit result taken as signed: bit 2 means negative, bit 1 positive and bit 0 zero. Exactly one of these bits is set. With `rc`=0, `cond` is 000.
- R12: After reset `busy`, `done`, `result`, `ovf` and `cond` are all zero. `result`, `ovf` and `cond` change only in a cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| op | input | 4 | Operation code (0 to 9) |
| oe | input | 1 | Enable overflow reporting |
| rc | input | 1 | Enable the comparison field |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B (immediate in bits 15:0 for code 6) |
| opc | input | 64 | Addend for multiply-add codes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Selected product slice |
| ovf | output | 1 | Overflow of low-half forms |
| cond | output | 3 | Negative / positive / zero of the result |

## Verification
The hardest state to reach from the ports is a `start` that arrives in the middle of an iteration. To show that it is dropped, the result must prove to be the first operation's, and the bench must keep watching long enough to see that no second `done` appears. A directed test pulses `start` with different operands a few cycles into a run, then watches for more than a full doubleword latency afterwards. The sign-boundary operands are a second concern. These are the most negative doubleword, an all-ones unsigned operand, and word products that spill exactly one bit past 32. They appear in the stimulus table so that the magnitude path, the final negation and both overflow windows are driven at their edges.

// File: rtl/mulx_pkg.sv
package mulx_pkg;

    typedef enum logic [3:0] {
        OP_MUL_LO_D   = 4'd0,
        OP_MUL_HI_D   = 4'd1,
        OP_MUL_HI_DU  = 4'd2,
        OP_MUL_LO_W   = 4'd3,
        OP_MUL_HI_W   = 4'd4,
        OP_MUL_HI_WU  = 4'd5,
        OP_MUL_IMM    = 4'd6,
        OP_MADD_HI    = 4'd7,
        OP_MADD_HI_U  = 4'd8,
        OP_MADD_LO    = 4'd9
    } mul_op_e;

    typedef enum logic [1:0] { PICK_LO, PICK_HI, PICK_HW } pick_e;
    typedef enum logic [1:0] { ADD_NONE, ADD_SEXT, ADD_ZEXT } addend_e;
    typedef enum logic [1:0] { OVC_NONE, OVC_DWORD, OVC_WORD } ovchk_e;
    typedef enum logic [1:0] { ST_IDLE, ST_RUN, ST_FIN } mul_state_e;

    typedef struct packed {
        logic    word;
        logic    sgn;
        logic    imm;
        pick_e   pick;
        addend_e add;
        ovchk_e  ovc;
    } mul_dec_t;

    function automatic mul_dec_t decode_op(input logic [3:0] code);
        mul_dec_t d;
        d = '{word: 1'b0, sgn: 1'b1, imm: 1'b0, pick: PICK_LO, add: ADD_NONE, ovc: OVC_DWORD};
        case (code)
            OP_MUL_HI_D:  d.pick = PICK_HI;
            OP_MUL_HI_DU: begin d.pick = PICK_HI; d.sgn = 1'b0; end
            OP_MUL_LO_W:  begin d.word = 1'b1; d.ovc = OVC_WORD; end
            OP_MUL_HI_W:  begin d.word = 1'b1; d.pick = PICK_HW; end
            OP_MUL_HI_WU: begin d.word = 1'b1; d.pick = PICK_HW; d.sgn = 1'b0; end
            OP_MUL_IMM:   d.imm = 1'b1;
            OP_MADD_HI:   begin d.pick = PICK_HI; d.add = ADD_SEXT; end
            OP_MADD_HI_U: begin d.pick = PICK_HI; d.add = ADD_ZEXT; d.sgn = 1'b0; end
            OP_MADD_LO:   d.add = ADD_SEXT;
            default:      ;
        endcase
        if (d.pick != PICK_LO || d.imm || d.add != ADD_NONE) begin
            if (d.ovc == OVC_DWORD) d.ovc = OVC_NONE;
        end
        return d;
    endfunction

endpackage

// File: rtl/mulx_shift_add.sv
module mulx_shift_add #(
    parameter int unsigned XLEN = 64
) (
    input  logic              clk,
    input  logic              load,
    input  logic              step,
    input  logic [XLEN-1:0]   mcand,
    input  logic [XLEN-1:0]   mplier,
    output logic [2*XLEN-1:0] prod
);
    logic [XLEN-1:0] mc_q;
    logic [XLEN-1:0] hi_q;
    logic [XLEN-1:0] lo_q;
    logic [XLEN:0]   partial;

    always_comb begin
        partial = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mc_q} : '0);
    end

    always_ff @(posedge clk) begin
        if (load) begin
            mc_q <= mcand;
            hi_q <= '0;
            lo_q <= mplier;
        end else if (step) begin
            {hi_q, lo_q} <= {partial, lo_q[XLEN-1:1]};
        end
    end

    assign prod = {hi_q, lo_q};
endmodule

// File: rtl/mulx_finish.sv
module mulx_finish
    import mulx_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [2*XLEN-1:0] raw,
    input  mul_dec_t          dec,
    input  logic              neg,
    input  logic [XLEN-1:0]   addend,
    input  logic              oe,
    input  logic              rc,
    output logic [XLEN-1:0]   res,
    output logic              ovf,
    output logic [2:0]        cond
);
    localparam int unsigned HALF = XLEN / 2;
    localparam int unsigned PW   = 2 * XLEN;

    logic [PW-1:0]   aligned;
    logic [PW-1:0]   signed_p;
    logic [PW-1:0]   ext;
    logic [PW-1:0]   sum;
    logic [XLEN:0]   top_d;
    logic [HALF:0]   top_w;

    always_comb begin
        aligned  = dec.word ? (raw >> HALF) : raw;
        signed_p = neg ? (PW'(0) - aligned) : aligned;
        case (dec.add)
            ADD_SEXT: ext = {{XLEN{addend[XLEN-1]}}, addend};
            ADD_ZEXT: ext = {{XLEN{1'b0}}, addend};
            default:  ext = '0;
        endcase
        sum = signed_p + ext;

        case (dec.pick)
            PICK_HI: res = sum[PW-1:XLEN];
            PICK_HW: res = {sum[XLEN-1:HALF], sum[XLEN-1:HALF]};
            default: res = sum[XLEN-1:0];
        endcase

        top_d = sum[PW-1:XLEN-1];
        top_w = sum[XLEN-1:HALF-1];
        case (dec.ovc)
            OVC_DWORD: ovf = oe & ~((&top_d) | ~(|top_d));
            OVC_WORD:  ovf = oe & ~((&top_w) | ~(|top_w));
            default:   ovf = 1'b0;
        endcase

        if (rc) cond = {res[XLEN-1], ~res[XLEN-1] & (|res), ~(|res)};
        else    cond = 3'b000;
    end
endmodule

// File: rtl/mulx_unit.sv
module mulx_unit
    import mulx_pkg::*;
#(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned IMM_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [3:0]      op,
    input  logic            oe,
    input  logic            rc,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic [XLEN-1:0] opc,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] result,
    output logic            ovf,
    output logic [2:0]      cond
);
    localparam int unsigned HALF  = XLEN / 2;
    localparam int unsigned CNT_W = $clog2(XLEN);
    localparam logic [CNT_W-1:0] LAST_W = CNT_W'(HALF - 1);
    localparam logic [CNT_W-1:0] LAST_D = CNT_W'(XLEN - 1);

    mul_state_e      state_q;
    mul_dec_t        dec_in, dec_q;
    logic [XLEN-1:0] a_ext, b_ext, a_mag, b_mag;
    logic            a_neg, b_neg;
    logic            neg_q, oe_q, rc_q;
    logic [XLEN-1:0] c_q;
    logic [CNT_W-1:0] cnt_q;
    logic            accept;
    logic [2*XLEN-1:0] raw;
    logic [XLEN-1:0] fin_res;
    logic            fin_ovf;
    logic [2:0]      fin_cond;

    always_comb begin
        dec_in = decode_op(op);
        if (dec_in.word) a_ext = {{HALF{dec_in.sgn & opa[HALF-1]}}, opa[HALF-1:0]};
        else             a_ext = opa;
        if (dec_in.imm)       b_ext = {{(XLEN-IMM_W){opb[IMM_W-1]}}, opb[IMM_W-1:0]};
        else if (dec_in.word) b_ext = {{HALF{dec_in.sgn & opb[HALF-1]}}, opb[HALF-1:0]};
        else                  b_ext = opb;
        a_neg  = dec_in.sgn & a_ext[XLEN-1];
        b_neg  = dec_in.sgn & b_ext[XLEN-1];
        a_mag  = a_neg ? (XLEN'(0) - a_ext) : a_ext;
        b_mag  = b_neg ? (XLEN'(0) - b_ext) : b_ext;
        accept = (state_q == ST_IDLE) && start;
    end

    mulx_shift_add #(.XLEN(XLEN)) u_core (
        .clk    (clk),
        .load   (accept),
        .step   (state_q == ST_RUN),
        .mcand  (a_mag),
        .mplier (b_mag),
        .prod   (raw)
    );

    mulx_finish #(.XLEN(XLEN)) u_finish (
        .raw    (raw),
        .dec    (dec_q),
        .neg    (neg_q),
        .addend (c_q),
        .oe     (oe_q),
        .rc     (rc_q),
        .res    (fin_res),
        .ovf    (fin_ovf),
        .cond   (fin_cond)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            busy    <= 1'b0;
            done    <= 1'b0;
            result  <= '0;
            ovf     <= 1'b0;
            cond    <= 3'b000;
            cnt_q   <= '0;
            dec_q   <= decode_op(4'd0);
            neg_q   <= 1'b0;
            oe_q    <= 1'b0;
            rc_q    <= 1'b0;
            c_q     <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        dec_q   <= dec_in;
                        neg_q   <= a_neg ^ b_neg;
                        oe_q    <= oe;
                        rc_q    <= rc;
                        c_q     <= opc;
                        cnt_q   <= '0;
                        busy    <= 1'b1;
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == (dec_q.word ? LAST_W : LAST_D)) state_q <= ST_FIN;
                end
                default: begin
                    result  <= fin_res;
                    ovf     <= fin_ovf;
                    cond    <= fin_cond;
                    done    <= 1'b1;
                    busy    <= 1'b0;
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/mulx_unit_chk.sv
module mulx_unit_chk #(
    parameter int unsigned XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic [XLEN-1:0] result,
    input logic            ovf,
    input logic [2:0]      cond
);
    p_accept_r1: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !done) |=> busy);
    p_done_idle_r1: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    p_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_busy_until_done_r2: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy || done));
    p_hold_outputs_r12: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(result) && $stable(ovf) && $stable(cond)));
    p_cond_onehot_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cond));
endmodule

bind mulx_unit mulx_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result),
    .ovf    (ovf),
    .cond   (cond)
);

// File: tb/mulx_unit_test.sv
module mulx_unit_test;
    localparam int unsigned XLEN = 64;
    localparam int NVEC = 16;

    typedef struct packed {
        logic [3:0]  op;
        logic        oe;
        logic        rc;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] c;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{4'd0, 1'b1, 1'b1, 64'd3, 64'hFFFF_FFFF_FFFF_FFFB, 64'd0},
        '{4'd0, 1'b1, 1'b0, 64'h4000_0000_0000_0000, 64'd4, 64'd0},
        '{4'd1, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'd0},
        '{4'd2, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0},
        '{4'd3, 1'b1, 1'b1, 64'hFFFF_FFFF_0001_0000, 64'h1234_5678_0001_0000, 64'd0},
        '{4'd3, 1'b1, 1'b1, 64'h0000_0000_FFFF_FFFD, 64'hABCD_0000_0000_0007, 64'd0},
        '{4'd4, 1'b0, 1'b1, 64'h0000_0000_8000_0000, 64'd2, 64'd0},
        '{4'd5, 1'b0, 1'b1, 64'h0000_0000_8000_0000, 64'd2, 64'd0},
        '{4'd6, 1'b0, 1'b1, 64'd1000, 64'hABCD_1234_5678_FFF6, 64'd0},
        '{4'd7, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF},
        '{4'd8, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
        '{4'd9, 1'b0, 1'b1, 64'd5, 64'd6, 64'hFFFF_FFFF_FFFF_FFE2},
        '{4'd0, 1'b0, 1'b1, 64'h4000_0000_0000_0000, 64'd4, 64'd0},
        '{4'd1, 1'b1, 1'b1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'd0},
        '{4'd2, 1'b1, 1'b0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'd0},
        '{4'd3, 1'b1, 1'b1, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 64'd0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [3:0] op = 4'd0;
    logic oe = 1'b0, rc = 1'b0;
    logic [63:0] opa = '0, opb = '0, opc = '0;
    logic busy, done, ovf;
    logic [63:0] result;
    logic [2:0] cond;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    mulx_unit #(.XLEN(XLEN)) uut (
        .clk(clk), .rst(rst), .start(start), .op(op), .oe(oe), .rc(rc),
        .opa(opa), .opb(opb), .opc(opc), .busy(busy), .done(done),
        .result(result), .ovf(ovf), .cond(cond)
    );

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] code);
        case (code)
            4'd1, 4'd2:       return "R5";
            4'd3:             return "R6";
            4'd4, 4'd5:       return "R7";
            4'd6:             return "R8";
            4'd7, 4'd8, 4'd9: return "R9";
            default:          return "R4";
        endcase
    endfunction

    function automatic logic [127:0] sx(input logic [63:0] v);
        return {{64{v[63]}}, v};
    endfunction

    task automatic reference(input vec_t v, output logic [63:0] r, output logic f, output logic [2:0] cf);
        logic [127:0] ea, eb, p, s;
        ea = sx(v.a); eb = sx(v.b); s = '0;
        case (v.op)
            4'd2, 4'd8: begin ea = {64'd0, v.a}; eb = {64'd0, v.b}; end
            4'd3, 4'd4: begin ea = sx({{32{v.a[31]}}, v.a[31:0]}); eb = sx({{32{v.b[31]}}, v.b[31:0]}); end
            4'd5:       begin ea = {96'd0, v.a[31:0]}; eb = {96'd0, v.b[31:0]}; end
            4'd6:       eb = sx({{48{v.b[15]}}, v.b[15:0]});
            default: ;
        endcase
        p = ea * eb;
        if (v.op == 4'd7 || v.op == 4'd9) s = sx(v.c);
        if (v.op == 4'd8) s = {64'd0, v.c};
        p = p + s;
        case (v.op)
            4'd1, 4'd2, 4'd7, 4'd8: r = p[127:64];
            4'd4, 4'd5:             r = {p[63:32], p[63:32]};
            default:                r = p[63:0];
        endcase
        f = 1'b0;
        if (v.oe && v.op == 4'd0) f = !(p[127:63] == '0 || p[127:63] == '1);
        if (v.oe && v.op == 4'd3) f = !(p[63:31] == '0 || p[63:31] == '1);
        if (!v.rc)             cf = 3'b000;
        else if (r == 64'd0)   cf = 3'b001;
        else if (r[63])        cf = 3'b100;
        else                   cf = 3'b010;
    endtask

    task automatic launch(input vec_t v);
        @(negedge clk);
        op = v.op; oe = v.oe; rc = v.rc; opa = v.a; opb = v.b; opc = v.c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int cycles);
        cycles = 0;
        do begin
            @(negedge clk);
            cycles++;
        end while (!done && cycles < 300);
    endtask

    task automatic run_vec(input vec_t v);
        int cyc, lat;
        logic [63:0] er;
        logic ef;
        logic [2:0] ec;
        string t;
        reference(v, er, ef, ec);
        t = tag_of(v.op);
        launch(v);
        wait_done(cyc);
        lat = (v.op == 4'd3 || v.op == 4'd4 || v.op == 4'd5) ? 33 : 65;
        check("R3", "latency", 64'(cyc), 64'(lat));
        check(t, "result", result, er);
        check("R10", "ovf", {63'd0, ovf}, {63'd0, ef});
        check("R11", "cond", {61'd0, cond}, {61'd0, ec});
        check("R1", "busy low at done", {63'd0, busy}, 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int cyc;
        logic [63:0] held;
        vec_t v1, v2;
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", "busy after reset", {63'd0, busy}, 64'd0);
        check("R12", "done after reset", {63'd0, done}, 64'd0);
        check("R12", "result after reset", result, 64'd0);
        check("R12", "ovf/cond after reset", {60'd0, ovf, cond}, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

        // R1: busy observed high in the cycle after acceptance
        v1 = '{4'd0, 1'b0, 1'b0, 64'd3, 64'd4, 64'd0};
        launch(v1);
        check("R1", "busy after accept", {63'd0, busy}, 64'd1);

        // R2: start while busy is ignored
        repeat (4) @(negedge clk);
        v2 = '{4'd3, 1'b0, 1'b0, 64'd7, 64'd7, 64'd0};
        op = v2.op; opa = v2.a; opb = v2.b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(cyc);
        check("R2", "first result kept", result, 64'd12);
        check("R2", "latency unchanged", 64'(cyc + 5), 64'd65);
        held = result;
        cyc = 0;
        for (int k = 0; k < 90; k++) begin
            @(negedge clk);
            if (done || busy) cyc++;
        end
        check("R2", "no second operation", 64'(cyc), 64'd0);
        // R12: outputs hold between operations
        check("R12", "result held", result, held);

        // R6: upper operand halves ignored in word form
        run_vec('{4'd3, 1'b1, 1'b1, 64'h5555_5555_0000_0009, 64'hAAAA_AAAA_FFFF_FFFF, 64'd0});
        // R8: immediate upper bits ignored
        run_vec('{4'd6, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_0003, 64'd0});
        // R10: low-doubleword boundary just inside the signed range (no overflow)
        run_vec('{4'd0, 1'b1, 1'b1, 64'h4000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFE, 64'd0});

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule